// File: doc/BRIEF.md
# I2C Master Bus Condition Sequencer

This block produces the bus conditions an I2C master needs around its data bytes: a start from a free bus, a repeated start while the bus is held busy, and a stop that hands the bus back. Software raises a start-request or stop-request bit and sets an enable bit. Each request bit reads back as 1 until the block has put the matching condition on the wires, then clears itself. Software polls it to learn that the condition has been produced.

Timing comes from an external timer tick. One tick is one quarter of an SCL period. Every condition is a short list of line patterns, and each pattern is held for one tick. Both lines are modelled as open-drain pull enables, where 1 pulls the wire low. After the block releases SCL, it reads the wire back and does not move on while a target holds SCL low.

A small stub stands in for the byte engine. It provides the transmit-busy and receive-busy flags. Conditions are held off until these flags are low and a guard time of several ticks has passed since the last byte finished.

Top module: `i2c_cond_seq`

## Requirements
- R1: A start request on a free bus drives the pattern (SCL released, SDA pulled), then (SCL pulled, SDA pulled), one tick each. At the end, bus-busy goes to 1 and the start-request bit clears. Both lines then stay pulled (holding state).
- R2: A start request while bus-busy is 1 drives four patterns: (SCL pulled, SDA released), (both released), (SCL released, SDA pulled), (both pulled). SDA therefore falls while SCL is high. The start-request bit then clears and bus-busy stays 1.
- R3: A stop request drives (both pulled), (SCL released, SDA pulled), (both released). SDA therefore rises while SCL is high. Afterwards the stop-request bit and bus-busy are both 0, and both lines are released.
- R4: A request bit reads 1 from the cycle after its write until the cycle in which its condition completes.
- R5: A stop write while bus-busy is 0 is ignored, and the stop-request bit stays 0.
- R6: A start or stop write is ignored while a request is pending or a sequence is running.
- R7: A pending request does not start its sequence while transmit-busy or receive-busy is 1, nor until GUARD_TICKS ticks have passed since the later of the two fell.
- R8: While SCL is released and the SCL input reads low, the sequence does not advance and neither pull output changes.
- R9: When enable is 0, on the next cycle both pulls, bus-busy, both request bits and both byte-busy flags are 0. Writes made while enable is 0 are ignored.
- R10: A transmit-go or receive-go is accepted only when bus-busy is 1, no request is pending and no byte is in progress. The accepted flag stays 1 for BYTE_TICKS ticks, and the two flags are never 1 together.
- R11: After reset, every output is 0.
- R12: While enable stays 1, SCL pull and SDA pull never change in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Enable bit |
| strt_wr_i | input | 1 | One-cycle write of 1 to the start-request bit |
| stp_wr_i | input | 1 | One-cycle write of 1 to the stop-request bit |
| tick_i | input | 1 | Quarter-period timer tick |
| scl_i | input | 1 | SCL wire level read back |
| tx_go_i | input | 1 | Start one byte transmit (stub) |
| rx_go_i | input | 1 | Start one byte receive (stub) |
| scl_pull_o | output | 1 | 1 pulls SCL low |
| sda_pull_o | output | 1 | 1 pulls SDA low |
| bus_busy_o | output | 1 | Bus is owned by this master |
| strt_o | output | 1 | Start-request bit read-back |
| stp_o | output | 1 | Stop-request bit read-back |
| tx_busy_o | output | 1 | Transmit byte in progress |
| rx_busy_o | output | 1 | Receive byte in progress |

## Verification
The assertions check on every cycle that the two pull outputs never move together while enabled, that a stalled SCL freezes the line pattern, and that a stop request appears only on a busy bus. They also check that bus-busy and the stop bit fall only with both lines released, that disabling clears everything, and that the request bits and byte flags stay exclusive. The order of the patterns, which yields start and stop edges on the wires, can only be shown by the bench scenarios. The bench also counts conditions, holds a pending request across a byte and its guard time, stretches the clock, and confirms that writes are dropped.

// File: rtl/i2c_cs_pkg.sv
// Shared types and step tables for the I2C condition sequencer.
// Assumes one timer tick equals a quarter SCL period.
package i2c_cs_pkg;

    typedef enum logic [1:0] {
        K_START  = 2'd0,
        K_RSTART = 2'd1,
        K_STOP   = 2'd2
    } cond_kind_e;

    localparam int STEP_W = 2;

    // Index of the final pattern of each condition.
    function automatic logic [STEP_W-1:0] last_step(cond_kind_e k);
        case (k)
            K_START:  last_step = 2'd1;
            K_RSTART: last_step = 2'd3;
            default:  last_step = 2'd2;
        endcase
    endfunction

    // Line pattern {scl_pull, sda_pull} held during step s of condition k.
    function automatic logic [1:0] pull_pattern(cond_kind_e k, logic [STEP_W-1:0] s);
        logic [1:0] p;
        p = 2'b11;
        case (k)
            K_START: begin
                case (s)
                    2'd0:    p = 2'b01;
                    default: p = 2'b11;
                endcase
            end
            K_RSTART: begin
                case (s)
                    2'd0:    p = 2'b10;
                    2'd1:    p = 2'b00;
                    2'd2:    p = 2'b01;
                    default: p = 2'b11;
                endcase
            end
            default: begin
                case (s)
                    2'd0:    p = 2'b11;
                    2'd1:    p = 2'b01;
                    default: p = 2'b00;
                endcase
            end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/i2c_cs_req.sv
// Request register pair: holds the start and stop request bits.
// Accepts a write only when idle with nothing pending; clears a bit when its
// condition completes. Start wins when both are written together.
module i2c_cs_req
    import i2c_cs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       strt_wr_i,
    input  logic       stp_wr_i,
    input  logic       bus_busy_i,
    input  logic       seq_active_i,
    input  logic       done_i,
    input  cond_kind_e done_kind_i,
    output logic       strt_q_o,
    output logic       stp_q_o
);

    logic accept;

    // New writes only land when the sequencer is quiet.
    always_comb accept = en_i && !seq_active_i && !strt_q_o && !stp_q_o;

    // Set on accepted write, clear on completion or disable.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            strt_q_o <= 1'b0;
            stp_q_o  <= 1'b0;
        end else if (done_i) begin
            if (done_kind_i == K_STOP) stp_q_o  <= 1'b0;
            else                       strt_q_o <= 1'b0;
        end else if (accept) begin
            if (strt_wr_i)                    strt_q_o <= 1'b1;
            else if (stp_wr_i && bus_busy_i)  stp_q_o  <= 1'b1;
        end
    end

endmodule

// File: rtl/i2c_cs_steps.sv
// Step sequencer: walks the pattern list of one condition, one tick per step.
// Assumes launch_i is only raised while inactive. Waits on a released SCL
// that reads low (clock stretching).
module i2c_cs_steps
    import i2c_cs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_i,
    input  logic       launch_i,
    input  cond_kind_e launch_kind_i,
    input  logic       tick_i,
    input  logic       scl_i,
    output logic       active_o,
    output cond_kind_e kind_o,
    output logic       scl_pull_o,
    output logic       sda_pull_o,
    output logic       bus_busy_o,
    output logic       done_o
);

    logic [STEP_W-1:0] step_q;
    logic              advance;
    logic [1:0]        first_pat;
    logic [1:0]        next_pat;

    // A step ends on a tick unless SCL was released and is still low.
    always_comb advance = active_o && tick_i && (scl_pull_o || scl_i);

    // Completion is the advance out of the final step.
    always_comb done_o = advance && (step_q == last_step(kind_o));

    // Patterns for the first step and the following step.
    always_comb begin
        first_pat = pull_pattern(launch_kind_i, '0);
        next_pat  = pull_pattern(kind_o, step_q + 1'b1);
    end

    // Step state, line drives and bus ownership.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            active_o   <= 1'b0;
            kind_o     <= K_START;
            step_q     <= '0;
            scl_pull_o <= 1'b0;
            sda_pull_o <= 1'b0;
            bus_busy_o <= 1'b0;
        end else if (launch_i) begin
            active_o   <= 1'b1;
            kind_o     <= launch_kind_i;
            step_q     <= '0;
            scl_pull_o <= first_pat[1];
            sda_pull_o <= first_pat[0];
        end else if (done_o) begin
            active_o   <= 1'b0;
            bus_busy_o <= (kind_o != K_STOP);
        end else if (advance) begin
            step_q     <= step_q + 1'b1;
            scl_pull_o <= next_pat[1];
            sda_pull_o <= next_pat[0];
        end
    end

endmodule

// File: rtl/i2c_cs_bytestub.sv
// Byte engine stand-in: raises transmit or receive busy for BYTE_TICKS ticks,
// then counts a guard time of GUARD_TICKS ticks before conditions may run.
module i2c_cs_bytestub #(
    parameter int BYTE_TICKS  = 36,
    parameter int GUARD_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic tick_i,
    input  logic allow_i,
    input  logic tx_go_i,
    input  logic rx_go_i,
    output logic tx_busy_o,
    output logic rx_busy_o,
    output logic ready_o
);

    localparam int CNT_W = $clog2(BYTE_TICKS + 1);
    localparam int GRD_W = $clog2(GUARD_TICKS + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_TICKS - 1);
    localparam logic [GRD_W-1:0] GRD_FULL = GRD_W'(GUARD_TICKS);

    logic [CNT_W-1:0] cnt_q;
    logic [GRD_W-1:0] grd_q;
    logic             idle;

    always_comb idle = !tx_busy_o && !rx_busy_o;

    // Conditions may proceed once idle and the guard has filled.
    always_comb ready_o = idle && (grd_q == GRD_FULL);

    // Byte timing and post-byte guard counting.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            tx_busy_o <= 1'b0;
            rx_busy_o <= 1'b0;
            cnt_q     <= '0;
            grd_q     <= GRD_FULL;
        end else if (idle) begin
            if (allow_i && (tx_go_i || rx_go_i)) begin
                tx_busy_o <= tx_go_i;
                rx_busy_o <= !tx_go_i;
                cnt_q     <= '0;
                grd_q     <= '0;
            end else if (tick_i && grd_q != GRD_FULL) begin
                grd_q <= grd_q + 1'b1;
            end
        end else if (tick_i) begin
            if (cnt_q == CNT_LAST) begin
                tx_busy_o <= 1'b0;
                rx_busy_o <= 1'b0;
                cnt_q     <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/i2c_cond_seq.sv
// Top of the I2C master condition sequencer. Joins the request bits, the
// step sequencer and the byte stub. Chooses the condition kind at launch:
// start request on a free bus gives START, on a busy bus a repeated START.
module i2c_cond_seq
    import i2c_cs_pkg::*;
#(
    parameter int BYTE_TICKS  = 36,
    parameter int GUARD_TICKS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic strt_wr_i,
    input  logic stp_wr_i,
    input  logic tick_i,
    input  logic scl_i,
    input  logic tx_go_i,
    input  logic rx_go_i,
    output logic scl_pull_o,
    output logic sda_pull_o,
    output logic bus_busy_o,
    output logic strt_o,
    output logic stp_o,
    output logic tx_busy_o,
    output logic rx_busy_o
);

    logic       seq_active;
    logic       seq_done;
    cond_kind_e seq_kind;
    cond_kind_e launch_kind;
    logic       launch;
    logic       eng_ready;
    logic       byte_allow;

    // Start a sequence when a request waits and the byte side is settled.
    always_comb begin
        launch      = en_i && !seq_active && (strt_o || stp_o) && eng_ready;
        launch_kind = strt_o ? (bus_busy_o ? K_RSTART : K_START) : K_STOP;
        byte_allow  = bus_busy_o && !seq_active && !strt_o && !stp_o;
    end

    i2c_cs_req u_req (
        .clk          (clk),
        .rst_n        (rst_n),
        .en_i         (en_i),
        .strt_wr_i    (strt_wr_i),
        .stp_wr_i     (stp_wr_i),
        .bus_busy_i   (bus_busy_o),
        .seq_active_i (seq_active),
        .done_i       (seq_done),
        .done_kind_i  (seq_kind),
        .strt_q_o     (strt_o),
        .stp_q_o      (stp_o)
    );

    i2c_cs_steps u_steps (
        .clk           (clk),
        .rst_n         (rst_n),
        .en_i          (en_i),
        .launch_i      (launch),
        .launch_kind_i (launch_kind),
        .tick_i        (tick_i),
        .scl_i         (scl_i),
        .active_o      (seq_active),
        .kind_o        (seq_kind),
        .scl_pull_o    (scl_pull_o),
        .sda_pull_o    (sda_pull_o),
        .bus_busy_o    (bus_busy_o),
        .done_o        (seq_done)
    );

    i2c_cs_bytestub #(
        .BYTE_TICKS  (BYTE_TICKS),
        .GUARD_TICKS (GUARD_TICKS)
    ) u_byte (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_i      (en_i),
        .tick_i    (tick_i),
        .allow_i   (byte_allow),
        .tx_go_i   (tx_go_i),
        .rx_go_i   (rx_go_i),
        .tx_busy_o (tx_busy_o),
        .rx_busy_o (rx_busy_o),
        .ready_o   (eng_ready)
    );

endmodule

// File: rtl/i2c_cond_seq_chk.sv
// Checker for the condition sequencer; bound to every instance of the top.
module i2c_cond_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic en_i,
    input logic scl_i,
    input logic seq_active,
    input logic scl_pull_o,
    input logic sda_pull_o,
    input logic bus_busy_o,
    input logic strt_o,
    input logic stp_o,
    input logic tx_busy_o,
    input logic rx_busy_o
);

    p_no_dual_edge_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && $past(en_i) && !$stable(scl_pull_o)) |-> $stable(sda_pull_o));

    p_stretch_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && seq_active && !scl_pull_o && !scl_i) |=> ($stable(scl_pull_o) && $stable(sda_pull_o)));

    p_free_lines_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_busy_o) |-> (!scl_pull_o && !sda_pull_o));

    p_stop_clears_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stp_o) |-> !bus_busy_o);

    p_stop_needs_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stp_o) |-> bus_busy_o);

    p_disable_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> (!scl_pull_o && !sda_pull_o && !bus_busy_o && !strt_o && !stp_o && !tx_busy_o && !rx_busy_o));

    p_single_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(strt_o && stp_o));

    p_byte_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tx_busy_o, rx_busy_o}));

    p_hold_during_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy_o || rx_busy_o) |-> !seq_active);

endmodule

bind i2c_cond_seq i2c_cond_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (en_i),
    .scl_i      (scl_i),
    .seq_active (seq_active),
    .scl_pull_o (scl_pull_o),
    .sda_pull_o (sda_pull_o),
    .bus_busy_o (bus_busy_o),
    .strt_o     (strt_o),
    .stp_o      (stp_o),
    .tx_busy_o  (tx_busy_o),
    .rx_busy_o  (rx_busy_o)
);

// File: tb/i2c_cond_seq_tb_top.sv
// Self-checking bench: a vector table of bus operations, then directed cases.
module i2c_cond_seq_tb_top;

    localparam int BYTE_TICKS  = 4;
    localparam int GUARD_TICKS = 2;
    localparam int OP_START = 0;
    localparam int OP_STOP  = 1;
    localparam int OP_TX    = 2;
    localparam int OP_RX    = 3;
    localparam int NVEC     = 7;
    // {operation, expected busy, expected start count, expected stop count}
    localparam int VEC [NVEC][4] = '{
        '{OP_START, 1, 1, 0},
        '{OP_TX,    1, 1, 0},
        '{OP_START, 1, 2, 0},
        '{OP_RX,    1, 2, 0},
        '{OP_STOP,  0, 2, 1},
        '{OP_START, 1, 3, 1},
        '{OP_STOP,  0, 3, 2}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_i = 1'b0;
    logic strt_wr_i = 1'b0;
    logic stp_wr_i = 1'b0;
    logic tick_i = 1'b0;
    logic tx_go_i = 1'b0;
    logic rx_go_i = 1'b0;
    logic slave_hold = 1'b0;
    logic scl_i;
    logic scl_pull_o, sda_pull_o, bus_busy_o, strt_o, stp_o, tx_busy_o, rx_busy_o;

    int checks = 0;
    int fails = 0;
    int n_start = 0;
    int n_stop = 0;
    int n_dual = 0;
    int tick_cnt = 0;
    logic prev_scl = 1'b1;
    logic prev_sda = 1'b1;
    logic prev_sp = 1'b0;
    logic prev_dp = 1'b0;
    logic prev_en = 1'b0;

    always #4 clk = ~clk;

    assign scl_i = !(scl_pull_o || slave_hold);

    i2c_cond_seq #(.BYTE_TICKS(BYTE_TICKS), .GUARD_TICKS(GUARD_TICKS)) dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en_i), .strt_wr_i(strt_wr_i), .stp_wr_i(stp_wr_i),
        .tick_i(tick_i), .scl_i(scl_i), .tx_go_i(tx_go_i), .rx_go_i(rx_go_i),
        .scl_pull_o(scl_pull_o), .sda_pull_o(sda_pull_o), .bus_busy_o(bus_busy_o),
        .strt_o(strt_o), .stp_o(stp_o), .tx_busy_o(tx_busy_o), .rx_busy_o(rx_busy_o)
    );

    // Quarter-period tick every fourth cycle, driven away from the edge.
    always @(negedge clk) begin
        tick_cnt <= (tick_cnt + 1) % 4;
        tick_i   <= (tick_cnt == 3);
    end

    // Wire monitor: counts start and stop edges and simultaneous pull changes.
    always @(negedge clk) begin
        if (rst_n && en_i && prev_en) begin
            if (prev_scl && scl_i && prev_sda && sda_pull_o) n_start++;
            if (prev_scl && scl_i && !prev_sda && !sda_pull_o) n_stop++;
            if ((prev_sp != scl_pull_o) && (prev_dp != sda_pull_o)) n_dual++;
        end
        prev_scl <= scl_i;
        prev_sda <= !sda_pull_o;
        prev_sp  <= scl_pull_o;
        prev_dp  <= sda_pull_o;
        prev_en  <= en_i;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_strt();
        @(negedge clk) strt_wr_i = 1'b1;
        @(negedge clk) strt_wr_i = 1'b0;
    endtask

    task automatic pulse_stp();
        @(negedge clk) stp_wr_i = 1'b1;
        @(negedge clk) stp_wr_i = 1'b0;
    endtask

    task automatic run_op(input int op);
        case (op)
            OP_START: begin
                pulse_strt();
                check(strt_o == 1'b1, "R4 start bit pending", int'(strt_o), 1);
                while (strt_o) @(negedge clk);
            end
            OP_STOP: begin
                pulse_stp();
                check(stp_o == 1'b1, "R4 stop bit pending", int'(stp_o), 1);
                while (stp_o) @(negedge clk);
            end
            OP_TX: begin
                @(negedge clk) tx_go_i = 1'b1;
                @(negedge clk) tx_go_i = 1'b0;
                check(tx_busy_o == 1'b1, "R10 tx accepted", int'(tx_busy_o), 1);
                while (tx_busy_o) @(negedge clk);
            end
            default: begin
                @(negedge clk) rx_go_i = 1'b1;
                @(negedge clk) rx_go_i = 1'b0;
                check(rx_busy_o == 1'b1, "R10 rx accepted", int'(rx_busy_o), 1);
                while (rx_busy_o) @(negedge clk);
            end
        endcase
        repeat (2) @(negedge clk);
    endtask

    task automatic main_seq();
        int s0;
        // R11: reset state
        repeat (3) @(negedge clk);
        check({scl_pull_o, sda_pull_o, bus_busy_o, strt_o, stp_o, tx_busy_o, rx_busy_o} == 7'b0,
              "R11 reset outputs", int'({scl_pull_o, sda_pull_o, bus_busy_o}), 0);
        rst_n = 1'b1;
        en_i  = 1'b1;
        repeat (2) @(negedge clk);

        // R5: stop on a free bus is dropped
        pulse_stp();
        check(stp_o == 1'b0, "R5 stop ignored when free", int'(stp_o), 0);
        // R10: byte go on a free bus is dropped
        @(negedge clk) tx_go_i = 1'b1;
        @(negedge clk) tx_go_i = 1'b0;
        check(tx_busy_o == 1'b0, "R10 tx ignored when free", int'(tx_busy_o), 0);

        // Table walk: R1 R2 R3 with condition counting
        for (int i = 0; i < NVEC; i++) begin
            run_op(VEC[i][0]);
            check(bus_busy_o == VEC[i][1][0], "R1/R2/R3 busy", int'(bus_busy_o), VEC[i][1]);
            check(n_start == VEC[i][2], "R1 R2 start edges", n_start, VEC[i][2]);
            check(n_stop == VEC[i][3], "R3 stop edges", n_stop, VEC[i][3]);
            check({scl_pull_o, sda_pull_o} == (VEC[i][1] != 0 ? 2'b11 : 2'b00),
                  "R1 R3 line state", int'({scl_pull_o, sda_pull_o}), VEC[i][1] != 0 ? 3 : 0);
        end

        // R6: stop write while a start is pending is dropped
        run_op(OP_START);
        pulse_strt();
        pulse_stp();
        check(stp_o == 1'b0, "R6 stop write dropped", int'(stp_o), 0);
        while (strt_o) @(negedge clk);
        check(bus_busy_o == 1'b1, "R2 busy kept", int'(bus_busy_o), 1);

        // R10: rx go while tx busy is dropped
        @(negedge clk) tx_go_i = 1'b1;
        @(negedge clk) begin tx_go_i = 1'b0; rx_go_i = 1'b1; end
        @(negedge clk) rx_go_i = 1'b0;
        check(rx_busy_o == 1'b0, "R10 rx dropped while tx", int'(rx_busy_o), 0);

        // R7: stop waits for byte end plus guard
        pulse_stp();
        check(stp_o == 1'b1, "R7 stop pending during byte", int'(stp_o), 1);
        s0 = n_stop;
        while (tx_busy_o) @(negedge clk);
        repeat (5) @(negedge clk);
        check({scl_pull_o, sda_pull_o} == 2'b11 && n_stop == s0, "R7 guard hold",
              int'({scl_pull_o, sda_pull_o}), 3);
        while (stp_o) @(negedge clk);
        check(n_stop == s0 + 1, "R7 stop after guard", n_stop, s0 + 1);

        // R8: stretched SCL stalls a repeated start
        run_op(OP_START);
        s0 = n_start;
        slave_hold = 1'b1;
        pulse_strt();
        while (scl_pull_o) @(negedge clk);
        repeat (40) @(negedge clk);
        check(!scl_pull_o && !sda_pull_o && strt_o && n_start == s0, "R8 stalled",
              int'({scl_pull_o, sda_pull_o, strt_o}), 1);
        slave_hold = 1'b0;
        while (strt_o) @(negedge clk);
        check(n_start == s0 + 1, "R8 resumes", n_start, s0 + 1);

        // R12: no simultaneous pull changes seen
        check(n_dual == 0, "R12 single line change", n_dual, 0);

        // R9: disable while busy clears everything and drops writes
        @(negedge clk) en_i = 1'b0;
        @(negedge clk);
        check({scl_pull_o, sda_pull_o, bus_busy_o, strt_o, stp_o} == 5'b0, "R9 cleared",
              int'({scl_pull_o, sda_pull_o, bus_busy_o, strt_o, stp_o}), 0);
        pulse_strt();
        check(strt_o == 1'b0, "R9 write ignored", int'(strt_o), 0);
    endtask

    initial begin
        fork
            main_seq();
            begin
                repeat (100000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog actual=0 expected=1");
            end
        join_any
        disable fork;
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule